// File: doc/BRIEF.md
# Next Program Counter Generator

This block owns the program counter of a simple 32-bit load/store core and decides, every cycle, which address the core fetches next. Four sources of address are available: straight-line flow (one word further on), a PC-relative conditional branch, a region-relative absolute jump (with or without saving a return address), and a jump through a register value. The decode stage of the core supplies a three-bit flow code, the immediate and target fields of the instruction, a register operand and the result of the branch comparison. The block returns the chosen address and the return address for the link register.

The program counter is held inside the block and reloads from the chosen address on every rising clock edge. A synchronous, active-high reset puts it at zero. The branch comparison itself is made outside, and so is instruction fetch. There are no delay slots: the link value points at the word right after the current one.

Top module: `nextpc_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `pcQ` becomes 0x00000000 at that edge.
- R2: With `flowSel` equal to 0, or to one of the unused codes 5, 6 or 7, `pcNext` equals `pcQ + 4`, wrapping modulo 2^32.
- R3: With `flowSel` equal to 1 and `condTaken` high, `pcNext` equals `pcQ + 4` plus `imm16` sign-extended from bit 15 and multiplied by 4. This gives a reach of -32768 to +32767 words from the following instruction.
- R4: With `flowSel` equal to 1 and `condTaken` low, `pcNext` equals `pcQ + 4`, whatever `imm16` holds.
- R5: With `flowSel` equal to 2, `pcNext` has bits 31:28 of `pcQ + 4` in bits 31:28, `tgt26` in bits 27:2 and zero in bits 1:0.
- R6: With `flowSel` equal to 3, `pcNext` follows the rule of R5. In every mode, `linkAddr` equals `pcQ + 4`, which is the return address for register 31.
- R7: With `flowSel` equal to 4, `pcNext` equals `regVal` with bits 1:0 forced to zero.
- R8: Outside reset, `pcQ` takes the value that `pcNext` held just before each rising edge.
- R9: Bits 1:0 of `pcNext` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| flowSel | input | 3 | Flow code: 0 sequential, 1 branch, 2 jump, 3 call, 4 register jump |
| condTaken | input | 1 | Branch comparison result |
| imm16 | input | 16 | Signed word offset of a branch |
| tgt26 | input | 26 | Word target of a jump or call |
| regVal | input | 32 | Register operand for a register jump |
| pcQ | output | 32 | Current program counter |
| pcNext | output | 32 | Address chosen for the next cycle |
| linkAddr | output | 32 | Return address, `pcQ + 4` |

## Verification
The bench builds the block with its default widths: a 32-bit address, a 16-bit offset and a 26-bit target, which leaves a 4-bit region. With these widths the stimulus can reach the largest forward and backward branch offsets, a jump that must keep a nonzero region, sequential flow that steps across a region boundary, and the wrap of the address from all ones back to zero. A register jump with all ones in `regVal` shows the forced alignment, and a reset partway through the run shows that the counter restarts at zero.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  typedef enum logic [2:0] {
    FLOW_SEQ    = 3'd0,
    FLOW_BRANCH = 3'd1,
    FLOW_JUMP   = 3'd2,
    FLOW_CALL   = 3'd3,
    FLOW_REGJMP = 3'd4
  } flowSel_e;

  // Strobes from the control to the datapath; at most one is high.
  typedef struct packed {
    logic takeBranch;
    logic takeRegion;
    logic takeReg;
  } pcStrobes_t;

endpackage

// File: rtl/nextpc_ctrl.sv
module nextpc_ctrl
  import nextpc_pkg::*;
(
  input  logic [2:0] flowSel,
  input  logic       condTaken,
  output pcStrobes_t strobes
);

  flowSel_e flowCode;

  always_comb begin
    flowCode = flowSel_e'(flowSel);
    strobes  = '0;
    unique case (flowCode)
      FLOW_BRANCH: strobes.takeBranch = condTaken;
      FLOW_JUMP,
      FLOW_CALL:   strobes.takeRegion = 1'b1;
      FLOW_REGJMP: strobes.takeReg    = 1'b1;
      default:     strobes            = '0;
    endcase
  end

endmodule

// File: rtl/nextpc_dp.sv
module nextpc_dp
  import nextpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26
) (
  input  logic [ADDR_W-1:0] pcQ,
  input  pcStrobes_t        strobes,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [TGT_W-1:0]  tgt26,
  input  logic [ADDR_W-1:0] regVal,
  output logic [ADDR_W-1:0] pcNext,
  output logic [ADDR_W-1:0] linkAddr
);

  localparam int WORD_SHIFT = 2;
  localparam int SEXT_W     = ADDR_W - IMM_W - WORD_SHIFT;
  localparam int REGION_W   = ADDR_W - TGT_W - WORD_SHIFT;
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);

  logic [ADDR_W-1:0] pcPlus4;
  logic [ADDR_W-1:0] branchOffset;
  logic [ADDR_W-1:0] branchTarget;
  logic [ADDR_W-1:0] regionTarget;
  logic [ADDR_W-1:0] regTarget;

  always_comb begin
    pcPlus4      = pcQ + WORD_BYTES;
    branchOffset = {{SEXT_W{imm16[IMM_W-1]}}, imm16, {WORD_SHIFT{1'b0}}};
    branchTarget = pcPlus4 + branchOffset;
    regionTarget = {pcPlus4[ADDR_W-1 -: REGION_W], tgt26, {WORD_SHIFT{1'b0}}};
    regTarget    = {regVal[ADDR_W-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}};
  end

  always_comb begin
    if (strobes.takeBranch)      pcNext = branchTarget;
    else if (strobes.takeRegion) pcNext = regionTarget;
    else if (strobes.takeReg)    pcNext = regTarget;
    else                         pcNext = pcPlus4;
  end

  assign linkAddr = pcPlus4;

endmodule

// File: rtl/nextpc_gen.sv
module nextpc_gen
  import nextpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int TGT_W  = 26,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        flowSel,
  input  logic              condTaken,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [TGT_W-1:0]  tgt26,
  input  logic [ADDR_W-1:0] regVal,
  output logic [ADDR_W-1:0] pcQ,
  output logic [ADDR_W-1:0] pcNext,
  output logic [ADDR_W-1:0] linkAddr
);

  pcStrobes_t strobes;

  nextpc_ctrl ctrl_i (
    .flowSel   (flowSel),
    .condTaken (condTaken),
    .strobes   (strobes)
  );

  nextpc_dp #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .TGT_W  (TGT_W)
  ) dp_i (
    .pcQ      (pcQ),
    .strobes  (strobes),
    .imm16    (imm16),
    .tgt26    (tgt26),
    .regVal   (regVal),
    .pcNext   (pcNext),
    .linkAddr (linkAddr)
  );

  always_ff @(posedge clk) begin
    if (rst) pcQ <= RESET_PC;
    else     pcQ <= pcNext;
  end

endmodule

// File: rtl/nextpc_gen_chk.sv
module nextpc_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 26
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        flowSel,
  input logic              condTaken,
  input logic [TGT_W-1:0]  tgt26,
  input logic [ADDR_W-1:0] regVal,
  input logic [ADDR_W-1:0] pcQ,
  input logic [ADDR_W-1:0] pcNext,
  input logic [ADDR_W-1:0] linkAddr
);

  localparam int REGION_W = ADDR_W - TGT_W - 2;

  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (pcQ == '0));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (flowSel == 3'd0) |=> (pcQ == $past(pcQ) + ADDR_W'(4)));

  assert_not_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (flowSel == 3'd1 && !condTaken) |-> (pcNext == linkAddr));

  assert_jump_region_R5: assert property (@(posedge clk) disable iff (rst)
    (flowSel == 3'd2) |-> (pcNext == {linkAddr[ADDR_W-1 -: REGION_W], tgt26, 2'b00}));

  assert_call_region_R6: assert property (@(posedge clk) disable iff (rst)
    (flowSel == 3'd3) |-> (pcNext == {linkAddr[ADDR_W-1 -: REGION_W], tgt26, 2'b00}));

  assert_reg_jump_R7: assert property (@(posedge clk) disable iff (rst)
    (flowSel == 3'd4) |-> (pcNext == {regVal[ADDR_W-1:2], 2'b00}));

  assert_pc_follows_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pcQ == $past(pcNext)));

  assert_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    (pcNext[1:0] == 2'b00));

endmodule

bind nextpc_gen nextpc_gen_chk #(
  .ADDR_W (ADDR_W),
  .TGT_W  (TGT_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .flowSel   (flowSel),
  .condTaken (condTaken),
  .tgt26     (tgt26),
  .regVal    (regVal),
  .pcQ       (pcQ),
  .pcNext    (pcNext),
  .linkAddr  (linkAddr)
);

// File: tb/nextpc_gen_tb_top.sv
module nextpc_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  typedef struct packed {
    logic [2:0]  sel;
    logic        cond;
    logic [15:0] imm;
    logic [25:0] tgt;
    logic [31:0] rv;
  } vec_t;

  // Stimulus rows; expected addresses are worked out by refModel below.
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 1'b0, 16'h0000, 26'h0000000, 32'h00000000},
    '{3'd0, 1'b1, 16'h1234, 26'h0000000, 32'h00000000},
    '{3'd1, 1'b1, 16'h0010, 26'h0000000, 32'h00000000},
    '{3'd1, 1'b0, 16'h7FFF, 26'h0000000, 32'h00000000},
    '{3'd1, 1'b1, 16'hFFFF, 26'h0000000, 32'h00000000},
    '{3'd3, 1'b0, 16'h0000, 26'h0123456, 32'h00000000},
    '{3'd4, 1'b0, 16'h0000, 26'h0000000, 32'h80001237},
    '{3'd2, 1'b0, 16'h0000, 26'h3FFFFFF, 32'h00000000},
    '{3'd0, 1'b0, 16'h0000, 26'h0000000, 32'h00000000},
    '{3'd1, 1'b1, 16'h8000, 26'h0000000, 32'h00000000},
    '{3'd5, 1'b1, 16'h0040, 26'h1111111, 32'h12345678},
    '{3'd4, 1'b0, 16'h0000, 26'h0000000, 32'hFFFFFFFF},
    '{3'd0, 1'b0, 16'h0000, 26'h0000000, 32'h00000000}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  flowSel;
  logic        condTaken;
  logic [15:0] imm16;
  logic [25:0] tgt26;
  logic [31:0] regVal;
  logic [31:0] pcQ, pcNext, linkAddr;

  int checks = 0;
  int errors = 0;
  logic [31:0] pcModel;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nextpc_gen dut_i (
    .clk(clk), .rst(rst), .flowSel(flowSel), .condTaken(condTaken),
    .imm16(imm16), .tgt26(tgt26), .regVal(regVal),
    .pcQ(pcQ), .pcNext(pcNext), .linkAddr(linkAddr)
  );

  function automatic logic [31:0] refModel(input logic [31:0] pc, input vec_t v);
    logic [31:0] p4;
    p4 = pc + 32'd4;
    case (v.sel)
      3'd1:    refModel = v.cond ? p4 + {{14{v.imm[15]}}, v.imm, 2'b00} : p4;
      3'd2,
      3'd3:    refModel = {p4[31:28], v.tgt, 2'b00};
      3'd4:    refModel = {v.rv[31:2], 2'b00};
      default: refModel = p4;
    endcase
  endfunction

  function automatic string reqOf(input vec_t v);
    case (v.sel)
      3'd1:    reqOf = v.cond ? "R3" : "R4";
      3'd2:    reqOf = "R5";
      3'd3:    reqOf = "R6";
      3'd4:    reqOf = "R7";
      default: reqOf = "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    flowSel = v.sel; condTaken = v.cond; imm16 = v.imm; tgt26 = v.tgt; regVal = v.rv;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive('{3'd0, 1'b0, 16'h0, 26'h0, 32'h0});
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset value", pcQ, 32'h0);
    rst = 1'b0;
    pcModel = 32'h0;

    // Table walk: combinational result before the edge, register after it.
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i]);
      #1;
      check(reqOf(VEC[i]), pcNext, refModel(pcModel, VEC[i]));
      check("R6 link", linkAddr, pcModel + 32'd4);
      check("R9 align", {30'h0, pcNext[1:0]}, 32'h0);
      pcModel = refModel(pcModel, VEC[i]);
      @(negedge clk);
      check("R8 register", pcQ, pcModel);
    end

    // Last row wrapped the counter past all ones (R2).
    check("R2 wrap", pcQ, 32'h0);

    // Branch not taken ignores the offset: register holds pc+4 (R4).
    drive('{3'd1, 1'b0, 16'h8000, 26'h0, 32'h0});
    @(negedge clk);
    check("R4 ignore offset", pcQ, 32'h4);

    // Mid-run reset (R1).
    drive('{3'd4, 1'b0, 16'h0, 26'h0, 32'h00ABCDE0});
    @(negedge clk);
    check("R7 reg jump", pcQ, 32'h00ABCDE0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", pcQ, 32'h0);
    rst = 1'b0;
    drive('{3'd2, 1'b0, 16'h0, 26'h0000001, 32'h0});
    @(negedge clk);
    check("R5 jump after reset", pcQ, 32'h4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule